// File: doc/BRIEF.md
# Multi-Domain Reset Tree Controller

This block turns three reset requests into clean, active-high resets for one primary clock domain and a set of regional clock domains. The requests are a power-on hold that the block makes itself after configuration, an external pushbutton request and a watchdog request. Any request asserts every reset output at once, with no clock edge needed, even when a clock is stopped. Each output releases only on a rising edge of the clock of its own domain, after a fixed number of edges.

Inside, a power-on hold counter and the two external requests are merged into one request. This request drives a primary shift-chain synchronizer in the primary domain, followed by optional register pipeline stages on the distributed net. The pipelined primary reset is the asynchronous input of one secondary synchronizer per region, each clocked by that region's clock. This keeps fan-out on the main reset net low. Region count, chain length, pipeline depth and power-on hold length are parameters.

Top module: `reset_tree`

## Requirements
- R1: While any request is high, `rstPrimary` and every bit of `rstRegion` are 1 within the same time step, with no clock edge needed. All resets and requests are active-high.
- R2: After configuration the power-on hold keeps the resets asserted for POR_CYCLES rising edges of `clkMain`. `rstPrimary` then falls on the edge numbered POR_CYCLES+SYNC_STAGES+PIPE_STAGES (edge 19 at the defaults, time 185 with edges at 5+10k). The power-on hold never returns on its own.
- R3: `extReq` alone and `wdogReq` alone each cause a full assertion and a full release sequence.
- R4: `rstPrimary` falls on the (SYNC_STAGES+PIPE_STAGES)-th rising edge of `clkMain` after the last request goes low, and not before.
- R5: Region r releases `rstRegion[r]` on the SYNC_STAGES-th rising edge of `clkRegion[r]` after `rstPrimary` falls.
- R6: No `rstRegion` bit is 0 while `rstPrimary` is 1.
- R7: A request shorter than one `clkMain` period still gives the full release sequence of R4 and R5, counted from the moment the request goes low.
- R8: A request raised during a release sequence, in the primary chain or in the regional chains, asserts every output again at once. The sequence then restarts from that request's fall.
- R9: Once released, an output stays 0 until a new request arrives.
- R10: With `clkMain` stopped, a request still asserts every output at once. `rstPrimary` stays 1 after the request falls until `clkMain` runs again, and the release edges are counted from the resumed clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkMain | input | 1 | Primary domain clock; also clocks the power-on hold counter |
| clkRegion | input | NUM_REGIONS | One clock per regional domain |
| extReq | input | 1 | External pushbutton reset request, active-high, asynchronous |
| wdogReq | input | 1 | Watchdog reset request, active-high, asynchronous |
| rstPrimary | output | 1 | Primary domain reset after the synchronizer and pipeline |
| rstRegion | output | NUM_REGIONS | Per-region reset, released on that region's own clock |

## Verification
On every sampled edge, the assertions check three things: a merged request is always seen as an asserted primary reset, no region stays released while the primary reset is asserted, and the power-on hold never comes back. The primary chain is also checked to release only after a quiet input edge. The exact release edges need the bench, as do immediate assertion from pulses that fall between edges, restarts in the middle of a sequence, and behaviour with a stopped clock. The bench computes each release time from the clock periods and phases and sweeps request source, pulse width and phase against the clock.

// File: rtl/reset_tree_pkg.sv
package reset_tree_pkg;

  // Strobes from the request merger to the distribution datapath.
  typedef struct packed {
    logic porHold;  // power-on hold still counting
    logic anyReq;   // OR of every request source
  } rstStrobes_t;

endpackage

// File: rtl/reset_tree_sync.sv
module reset_tree_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstIn,
  output logic rstOut
);

  // Power-up value of 1 matches the asserted state after configuration.
  logic [STAGES-1:0] chain = '1;
  logic pastValid = 1'b0;

  always_ff @(posedge clk or posedge rstIn) begin
    if (rstIn) chain <= '1;
    else       chain <= {chain[STAGES-2:0], 1'b0};
  end

  always_ff @(posedge clk) pastValid <= 1'b1;

  assign rstOut = chain[STAGES-1];

  // R4
  release_gap_chk: assert property (@(posedge clk) disable iff (rstIn)
    (pastValid && $fell(rstOut)) |-> $past(!rstIn));

endmodule

// File: rtl/reset_tree_ctrl.sv
module reset_tree_ctrl
  import reset_tree_pkg::*;
#(
  parameter int POR_CYCLES = 16
) (
  input  logic        clkMain,
  input  logic        extReq,
  input  logic        wdogReq,
  output rstStrobes_t strobes
);

  localparam int CNT_W = $clog2(POR_CYCLES + 1);

  // Loaded by configuration; counts down once and then stays at zero.
  logic [CNT_W-1:0] holdCnt = CNT_W'(POR_CYCLES);
  logic porHold;
  logic pastValid = 1'b0;

  always_ff @(posedge clkMain) begin
    if (holdCnt != '0) holdCnt <= holdCnt - CNT_W'(1);
  end

  always_ff @(posedge clkMain) pastValid <= 1'b1;

  assign porHold        = (holdCnt != '0);
  assign strobes.porHold = porHold;
  assign strobes.anyReq  = porHold | extReq | wdogReq;

  // R2
  por_sticky_chk: assert property (@(posedge clkMain) disable iff (extReq || wdogReq)
    (pastValid && $past(!porHold)) |-> !porHold);

endmodule

// File: rtl/reset_tree_dist.sv
module reset_tree_dist
  import reset_tree_pkg::*;
#(
  parameter int NUM_REGIONS = 3,
  parameter int SYNC_STAGES = 2,
  parameter int PIPE_STAGES = 1
) (
  input  logic                   clkMain,
  input  logic [NUM_REGIONS-1:0] clkRegion,
  input  rstStrobes_t            strobes,
  output logic                   rstPrimary,
  output logic [NUM_REGIONS-1:0] rstRegion
);

  logic anyReq;
  logic porHold;
  logic primSync;
  logic primDist;

  assign anyReq  = strobes.anyReq;
  assign porHold = strobes.porHold;

  reset_tree_sync #(.STAGES(SYNC_STAGES)) u_primary (
    .clk    (clkMain),
    .rstIn  (anyReq),
    .rstOut (primSync)
  );

  generate
    if (PIPE_STAGES > 0) begin : g_pipe
      // Pipeline flops are set by the raw request, so assertion skips them.
      logic [PIPE_STAGES-1:0] pipe = '1;
      logic [PIPE_STAGES:0]   pipeCat;
      assign pipeCat = {pipe, primSync};
      always_ff @(posedge clkMain or posedge anyReq) begin
        if (anyReq) pipe <= '1;
        else        pipe <= pipeCat[PIPE_STAGES-1:0];
      end
      assign primDist = pipe[PIPE_STAGES-1];
    end else begin : g_nopipe
      assign primDist = primSync;
    end
  endgenerate

  assign rstPrimary = primDist;

  generate
    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
      reset_tree_sync #(.STAGES(SYNC_STAGES)) u_secondary (
        .clk    (clkRegion[r]),
        .rstIn  (primDist),
        .rstOut (rstRegion[r])
      );

      // R6
      region_order_chk: assert property (@(posedge clkRegion[r]) disable iff (anyReq)
        !rstRegion[r] |-> !primDist);
    end
  endgenerate

  // R1
  req_covers_chk: assert property (@(posedge clkMain) disable iff (porHold)
    anyReq |-> primDist);

endmodule

// File: rtl/reset_tree.sv
module reset_tree
  import reset_tree_pkg::*;
#(
  parameter int NUM_REGIONS = 3,
  parameter int SYNC_STAGES = 2,
  parameter int PIPE_STAGES = 1,
  parameter int POR_CYCLES  = 16
) (
  input  logic                   clkMain,
  input  logic [NUM_REGIONS-1:0] clkRegion,
  input  logic                   extReq,
  input  logic                   wdogReq,
  output logic                   rstPrimary,
  output logic [NUM_REGIONS-1:0] rstRegion
);

  rstStrobes_t strobes;

  reset_tree_ctrl #(.POR_CYCLES(POR_CYCLES)) u_ctrl (
    .clkMain (clkMain),
    .extReq  (extReq),
    .wdogReq (wdogReq),
    .strobes (strobes)
  );

  reset_tree_dist #(
    .NUM_REGIONS (NUM_REGIONS),
    .SYNC_STAGES (SYNC_STAGES),
    .PIPE_STAGES (PIPE_STAGES)
  ) u_dist (
    .clkMain    (clkMain),
    .clkRegion  (clkRegion),
    .strobes    (strobes),
    .rstPrimary (rstPrimary),
    .rstRegion  (rstRegion)
  );

endmodule

// File: tb/reset_tree_bench.sv
module reset_tree_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NREG  = 3;
  localparam int SYNC  = 2;
  localparam int PIPE  = 1;
  localparam int POR   = 16;
  localparam int HALF0 = 4;
  localparam int HALF1 = 6;
  localparam int HALF2 = 8;

  logic clkFree = 1'b0;
  logic clkEn   = 1'b1;
  logic clkR0 = 1'b0, clkR1 = 1'b0, clkR2 = 1'b0;
  logic extReq = 1'b0, wdogReq = 1'b0;
  logic clkMain;
  logic [NREG-1:0] clkRegion;
  logic rstPrimary;
  logic [NREG-1:0] rstRegion;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  assign clkMain   = clkFree & clkEn;
  assign clkRegion = {clkR2, clkR1, clkR0};

  // Main rising edges at 5+10k (odd); region rising edges at even times.
  always #(CLK_PERIOD/2) clkFree = ~clkFree;
  always #HALF0 clkR0 = ~clkR0;
  always #HALF1 clkR1 = ~clkR1;
  always #HALF2 clkR2 = ~clkR2;

  reset_tree #(
    .NUM_REGIONS (NREG),
    .SYNC_STAGES (SYNC),
    .PIPE_STAGES (PIPE),
    .POR_CYCLES  (POR)
  ) u_reset_tree (
    .clkMain    (clkMain),
    .clkRegion  (clkRegion),
    .extReq     (extReq),
    .wdogReq    (wdogReq),
    .rstPrimary (rstPrimary),
    .rstRegion  (rstRegion)
  );

  function automatic longint halfOf(int r);
    case (r)
      0:       return HALF0;
      1:       return HALF1;
      default: return HALF2;
    endcase
  endfunction

  function automatic longint nextMainEdge(longint t);
    longint k = (t < CLK_PERIOD/2) ? 0 : (t - CLK_PERIOD/2) / CLK_PERIOD + 1;
    return CLK_PERIOD/2 + k * CLK_PERIOD;
  endfunction

  function automatic longint primaryRelease(longint tDrop);
    return nextMainEdge(tDrop) + (SYNC + PIPE - 1) * CLK_PERIOD;
  endfunction

  function automatic longint regionRelease(int r, longint tp);
    longint h = halfOf(r);
    longint k = (tp - h) / (2 * h) + 1;
    return h + 2 * h * (k + SYNC - 1);
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  task automatic checkAllHigh(string req);
    check(req, "rstPrimary asserted", rstPrimary, 1'b1);
    for (int r = 0; r < NREG; r++) check(req, "rstRegion asserted", rstRegion[r], 1'b1);
  endtask

  task automatic checkAllLow(string req);
    check(req, "rstPrimary released", rstPrimary, 1'b0);
    for (int r = 0; r < NREG; r++) check(req, "rstRegion released", rstRegion[r], 1'b0);
  endtask

  // R5: region release edge counted on the region's own clock
  task automatic regionCheck(int r, longint tp);
    longint tr = regionRelease(r, tp);
    #(tr - 1 - $time);
    check("R5", "rstRegion before release edge", rstRegion[r], 1'b1);
    #2;
    check("R5", "rstRegion after release edge", rstRegion[r], 1'b0);
  endtask

  task automatic checkRelease(longint tDrop, string req);
    longint tp = primaryRelease(tDrop);
    fork
      begin
        #(tp - 1 - $time);
        check(req, "rstPrimary before release edge", rstPrimary, 1'b1);
        #2;
        check(req, "rstPrimary after release edge", rstPrimary, 1'b0);
        for (int r = 0; r < NREG; r++)
          check("R6", "rstRegion held after primary release", rstRegion[r], 1'b1);
      end
      regionCheck(0, tp);
      regionCheck(1, tp);
      regionCheck(2, tp);
    join
    #3;
    checkAllLow("R9");
  endtask

  task automatic alignMain();
    #(CLK_PERIOD - int'($time % CLK_PERIOD));
  endtask

  task automatic pulse(int src, int d, int w);
    string req = (w < CLK_PERIOD) ? "R7" : ((src == 2) ? "R4" : "R3");
    alignMain();
    #(d);
    if (src != 1) extReq = 1'b1;
    if (src != 0) wdogReq = 1'b1;
    #1;
    checkAllHigh("R1");
    #(w - 1);
    extReq  = 1'b0;
    wdogReq = 1'b0;
    checkRelease($time, req);
  endtask

  initial begin
    #(100000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual run still busy expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    longint tp1;
    #2;
    // R1 R2: asserted from configuration with no request
    checkAllHigh("R2");
    checkRelease(CLK_PERIOD/2 + CLK_PERIOD * (POR - 1), "R2");

    // R3 R4 R7: source x phase x width sweep (phase 5 avoided, drops never hit an edge)
    for (int src = 0; src < 3; src++) begin
      for (int di = 0; di < 8; di++) begin
        int d = (di < 3) ? di : ((di == 3) ? 4 : di + 2);
        pulse(src, d, 2);
        pulse(src, d, 3 * CLK_PERIOD);
      end
    end

    // R8: restart while the primary chain is mid-sequence
    alignMain();
    #2;
    extReq = 1'b1;
    #3;
    extReq = 1'b0;
    #(nextMainEdge($time) + 2 - $time);
    check("R8", "rstPrimary mid-sequence", rstPrimary, 1'b1);
    wdogReq = 1'b1;
    #1;
    checkAllHigh("R8");
    #1;
    wdogReq = 1'b0;
    checkRelease($time, "R8");

    // R8: restart after primary release while regions are still counting
    alignMain();
    #2;
    extReq = 1'b1;
    #3;
    extReq = 1'b0;
    tp1 = primaryRelease($time);
    #(tp1 + 3 - $time);
    check("R8", "rstPrimary already released", rstPrimary, 1'b0);
    check("R8", "rstRegion still counting", rstRegion[0], 1'b1);
    extReq = 1'b1;
    #1;
    checkAllHigh("R8");
    #1;
    extReq = 1'b0;
    checkRelease($time, "R8");

    // R10: stopped primary clock
    alignMain();
    #2;
    clkEn = 1'b0;
    #10;
    extReq = 1'b1;
    #1;
    checkAllHigh("R10");
    #3;
    extReq = 1'b0;
    #50;
    checkAllHigh("R10");
    alignMain();
    #2;
    clkEn = 1'b1;
    checkRelease($time, "R10");

    // R2 R9: quiet period, nothing comes back
    #(20 * CLK_PERIOD);
    check("R2", "rstPrimary after long quiet period", rstPrimary, 1'b0);
    checkAllLow("R9");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule